// File: doc/BRIEF.md
# Fully Associative Address Translation Cache

This block keeps a small set of recent virtual-page to physical-page mappings and answers translation lookups against all of them at once. A lookup presents a virtual page number, the page offset and an access kind (read, write or execute). One cycle later the block reports either a hit, with the physical page number, the permission bits and the full physical address, or a miss. A miss means "ask the page-table walker"; it is not a fault.

After a miss the walker supplies the mapping through the refill port. The refill takes a free slot if one exists, replaces a slot already holding the same virtual page, or else evicts a slot chosen by a per-slot recently-used bit. Two invalidation commands remove every mapping, or only the mapping for one page. A write to a page whose stored modified bit is still clear is answered as a miss, so the walker can mark the page-table entry modified and refill with the bit set.

Top module: `tlb_fa`

## Requirements
- R1: After reset no slot holds a mapping: resp_valid_o is low and every lookup misses until a refill is made.
- R2: A lookup sampled on a clock edge gives resp_valid_o high for exactly the following cycle, with exactly one of resp_hit_o and resp_miss_o high; with no lookup, resp_valid_o, resp_hit_o and resp_miss_o are all low.
- R3: On a hit, resp_ppn_o and resp_perm_o (bit 2 read, bit 1 write, bit 0 execute) are those of the matching slot, and resp_pa_o equals {resp_ppn_o, offset of the lookup}.
- R4: A lookup whose page is held by no valid slot misses; on a miss resp_ppn_o and resp_perm_o are zero.
- R5: The access kind is encoded 0 read, 1 write, 2 execute. A write to a slot whose modified bit is clear misses; a read or execute to that slot hits, and a write to a slot with the modified bit set hits.
- R6: A refill goes to the lowest-indexed invalid slot when one exists; slots are filled 0, 1, 2 ... after an empty state.
- R7: A refill for a page already held overwrites that slot, so a page is never held twice, and the new physical page is returned on the next lookup.
- R8: The recently-used bit of a slot is set by a hit on it and by a refill into it. With every slot valid, a refill replaces the lowest-indexed slot whose used bit is clear.
- R9: With every slot valid and every used bit set, a refill clears all used bits and replaces slot 0, leaving only slot 0 marked used.
- R10: The invalidate-all command removes every mapping in one cycle; a lookup in the next cycle misses.
- R11: The invalidate-by-page command removes only the slot holding the given page; other mappings still hit.
- R12: When an invalidate command and a refill are asserted in the same cycle, the refill is dropped.
- R13: Looping over as many distinct pages as there are slots, refilling on each miss from an empty state, gives one miss per page in the first pass and only hits afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lookup_valid_i | input | 1 | Lookup request |
| lookup_vpn_i | input | VPN_W | Virtual page number to translate |
| lookup_off_i | input | OFF_W | Offset within the page |
| lookup_acc_i | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| refill_valid_i | input | 1 | Install a mapping |
| refill_vpn_i | input | VPN_W | Virtual page of the mapping |
| refill_ppn_i | input | PPN_W | Physical page of the mapping |
| refill_perm_i | input | 3 | Permissions: bit 2 read, bit 1 write, bit 0 execute |
| refill_dirty_i | input | 1 | Modified bit of the mapping |
| inv_all_i | input | 1 | Remove all mappings |
| inv_page_i | input | 1 | Remove the mapping of inv_vpn_i |
| inv_vpn_i | input | VPN_W | Page to remove |
| resp_valid_o | output | 1 | Response present (one cycle after a lookup) |
| resp_hit_o | output | 1 | Translation found |
| resp_miss_o | output | 1 | Walker must be consulted |
| resp_ppn_o | output | PPN_W | Physical page on a hit, zero on a miss |
| resp_perm_o | output | 3 | Permission bits on a hit, zero on a miss |
| resp_pa_o | output | PPN_W+OFF_W | Physical address |

## Verification
A wrong valid or page field in one slot shows as a hit where a miss is due, or the reverse, on the first lookup of that page, one cycle after it is presented. A wrong used bit stays hidden until the next refill with every slot full: the wrong slot is evicted, and that is seen only when the evicted and the surviving pages are looked up again. The bench therefore follows every refill on a full buffer with lookups of both the page expected to leave and pages expected to stay, and compares every response cycle against a behavioural model.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2
  } acc_e;

  typedef struct packed {
    logic rd;
    logic wr;
    logic ex;
  } perm_t;
endpackage

// File: rtl/tlb_fa_match.sv
module tlb_fa_match #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20
) (
  input  logic [ENTRIES-1:0]            valid_i,
  input  logic [ENTRIES-1:0][VPN_W-1:0] tab_vpn_i,
  input  logic [VPN_W-1:0]              key_i,
  output logic [ENTRIES-1:0]            match_o
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match_o[g] = valid_i[g] && (tab_vpn_i[g] == key_i);
  end
endmodule

// File: rtl/tlb_fa_penc.sv
module tlb_fa_penc #(
  parameter int N     = 16,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  // lowest set bit wins
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end
  assign found_o = |req_i;
endmodule

// File: rtl/tlb_fa_victim.sv
module tlb_fa_victim #(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ENTRIES-1:0] valid_i,
  input  logic [ENTRIES-1:0] used_i,
  output logic [IDX_W-1:0]   idx_o,
  output logic               all_used_o
);
  logic             free_found, cold_found;
  logic [IDX_W-1:0] free_idx, cold_idx;

  tlb_fa_penc #(.N(ENTRIES)) u_free (
    .req_i  (~valid_i),
    .found_o(free_found),
    .idx_o  (free_idx)
  );

  tlb_fa_penc #(.N(ENTRIES)) u_cold (
    .req_i  (valid_i & ~used_i),
    .found_o(cold_found),
    .idx_o  (cold_idx)
  );

  always_comb begin
    all_used_o = 1'b0;
    if (free_found)      idx_o = free_idx;
    else if (cold_found) idx_o = cold_idx;
    else begin
      idx_o      = '0;
      all_used_o = 1'b1;
    end
  end
endmodule

// File: rtl/tlb_fa.sv
module tlb_fa #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int OFF_W   = 12,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int PA_W   = PPN_W + OFF_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lookup_valid_i,
  input  logic [VPN_W-1:0] lookup_vpn_i,
  input  logic [OFF_W-1:0] lookup_off_i,
  input  logic [1:0]       lookup_acc_i,
  input  logic             refill_valid_i,
  input  logic [VPN_W-1:0] refill_vpn_i,
  input  logic [PPN_W-1:0] refill_ppn_i,
  input  logic [2:0]       refill_perm_i,
  input  logic             refill_dirty_i,
  input  logic             inv_all_i,
  input  logic             inv_page_i,
  input  logic [VPN_W-1:0] inv_vpn_i,
  output logic             resp_valid_o,
  output logic             resp_hit_o,
  output logic             resp_miss_o,
  output logic [PPN_W-1:0] resp_ppn_o,
  output logic [2:0]       resp_perm_o,
  output logic [PA_W-1:0]  resp_pa_o
);
  import tlb_pkg::*;

  logic [ENTRIES-1:0]            valid_q, used_q, dirty_q;
  logic [ENTRIES-1:0]            valid_d, used_d;
  logic [ENTRIES-1:0][VPN_W-1:0] vpn_q;
  logic [ENTRIES-1:0][PPN_W-1:0] ppn_q;
  perm_t [ENTRIES-1:0]           perm_q;

  logic [ENTRIES-1:0] lkp_hit_vec, ref_hit_vec, inv_hit_vec;
  logic               lkp_found, ref_found, inv_found_unused;
  logic [IDX_W-1:0]   lkp_idx, ref_idx, inv_idx_unused;
  logic [IDX_W-1:0]   vic_idx, wr_idx;
  logic               vic_all_used;
  logic               wr_clean, lkp_hit, ref_do;

  tlb_fa_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_match_lkp (
    .valid_i(valid_q), .tab_vpn_i(vpn_q), .key_i(lookup_vpn_i), .match_o(lkp_hit_vec)
  );
  tlb_fa_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_match_ref (
    .valid_i(valid_q), .tab_vpn_i(vpn_q), .key_i(refill_vpn_i), .match_o(ref_hit_vec)
  );
  tlb_fa_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_match_inv (
    .valid_i(valid_q), .tab_vpn_i(vpn_q), .key_i(inv_vpn_i), .match_o(inv_hit_vec)
  );

  tlb_fa_penc #(.N(ENTRIES)) u_enc_lkp (
    .req_i(lkp_hit_vec), .found_o(lkp_found), .idx_o(lkp_idx)
  );
  tlb_fa_penc #(.N(ENTRIES)) u_enc_ref (
    .req_i(ref_hit_vec), .found_o(ref_found), .idx_o(ref_idx)
  );
  // index unused: invalidation works on the whole match vector
  tlb_fa_penc #(.N(ENTRIES)) u_enc_inv (
    .req_i(inv_hit_vec), .found_o(inv_found_unused), .idx_o(inv_idx_unused)
  );

  tlb_fa_victim #(.ENTRIES(ENTRIES)) u_victim (
    .valid_i   (valid_q),
    .used_i    (used_q),
    .idx_o     (vic_idx),
    .all_used_o(vic_all_used)
  );

  // write to a clean page goes back to the walker to set the modified bit
  assign wr_clean = (lookup_acc_i == ACC_WRITE) && !dirty_q[lkp_idx];
  assign lkp_hit  = lookup_valid_i && lkp_found && !wr_clean;
  assign ref_do   = refill_valid_i && !inv_all_i && !inv_page_i;
  assign wr_idx   = ref_found ? ref_idx : vic_idx;

  always_comb begin
    valid_d = valid_q;
    used_d  = used_q;
    if (lkp_hit) used_d[lkp_idx] = 1'b1;
    if (inv_all_i) begin
      valid_d = '0;
      used_d  = '0;
    end else if (inv_page_i) begin
      valid_d = valid_q & ~inv_hit_vec;
      used_d  = used_d & ~inv_hit_vec;
    end else if (ref_do) begin
      if (!ref_found && vic_all_used) used_d = '0;
      used_d[wr_idx]  = 1'b1;
      valid_d[wr_idx] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      used_q  <= '0;
    end else begin
      valid_q <= valid_d;
      used_q  <= used_d;
    end
  end

  // payload needs no reset: guarded by valid_q
  always_ff @(posedge clk_i) begin
    if (ref_do) begin
      vpn_q[wr_idx]   <= refill_vpn_i;
      ppn_q[wr_idx]   <= refill_ppn_i;
      perm_q[wr_idx]  <= perm_t'(refill_perm_i);
      dirty_q[wr_idx] <= refill_dirty_i;
    end
  end

  logic             resp_valid_q, resp_hit_q, resp_miss_q;
  logic [PPN_W-1:0] resp_ppn_q;
  perm_t            resp_perm_q;
  logic [OFF_W-1:0] resp_off_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_valid_q <= 1'b0;
      resp_hit_q   <= 1'b0;
      resp_miss_q  <= 1'b0;
      resp_ppn_q   <= '0;
      resp_perm_q  <= '0;
      resp_off_q   <= '0;
    end else begin
      resp_valid_q <= lookup_valid_i;
      resp_hit_q   <= lkp_hit;
      resp_miss_q  <= lookup_valid_i && !lkp_hit;
      resp_ppn_q   <= lkp_hit ? ppn_q[lkp_idx] : '0;
      resp_perm_q  <= lkp_hit ? perm_q[lkp_idx] : '0;
      resp_off_q   <= lookup_off_i;
    end
  end

  assign resp_valid_o = resp_valid_q;
  assign resp_hit_o   = resp_hit_q;
  assign resp_miss_o  = resp_miss_q;
  assign resp_ppn_o   = resp_ppn_q;
  assign resp_perm_o  = resp_perm_q;
  assign resp_pa_o    = {resp_ppn_q, resp_off_q};
endmodule

// File: rtl/tlb_fa_chk.sv
module tlb_fa_chk #(
  parameter int ENTRIES = 16,
  parameter int PPN_W   = 20,
  parameter int OFF_W   = 12,
  localparam int PA_W   = PPN_W + OFF_W
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               lookup_valid_i,
  input logic [OFF_W-1:0]   lookup_off_i,
  input logic               inv_all_i,
  input logic               resp_valid_o,
  input logic               resp_hit_o,
  input logic               resp_miss_o,
  input logic [PPN_W-1:0]   resp_ppn_o,
  input logic [2:0]         resp_perm_o,
  input logic [PA_W-1:0]    resp_pa_o,
  input logic [ENTRIES-1:0] match_i
);
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  assert_resp_timing_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 2'd1) |-> (resp_valid_o == $past(lookup_valid_i)));

  assert_one_outcome_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o ? ($countones({resp_hit_o, resp_miss_o}) == 1) : !(resp_hit_o || resp_miss_o));

  assert_pa_offset_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((age_q >= 2'd1) && resp_valid_o) |-> (resp_pa_o[OFF_W-1:0] == $past(lookup_off_i)));

  assert_miss_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_miss_o |-> ((resp_ppn_o == '0) && (resp_perm_o == 3'b000)));

  assert_no_dup_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(match_i) <= 1);

  assert_flush_miss_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((age_q >= 2'd2) && $past(inv_all_i, 2) && $past(lookup_valid_i)) |-> resp_miss_o);
endmodule

bind tlb_fa tlb_fa_chk #(.ENTRIES(ENTRIES), .PPN_W(PPN_W), .OFF_W(OFF_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .lookup_valid_i(lookup_valid_i),
  .lookup_off_i  (lookup_off_i),
  .inv_all_i     (inv_all_i),
  .resp_valid_o  (resp_valid_o),
  .resp_hit_o    (resp_hit_o),
  .resp_miss_o   (resp_miss_o),
  .resp_ppn_o    (resp_ppn_o),
  .resp_perm_o   (resp_perm_o),
  .resp_pa_o     (resp_pa_o),
  .match_i       (lkp_hit_vec)
);

// File: tb/tlb_fa_test.sv
module tlb_fa_test;
  localparam int N      = 16;
  localparam int VW     = 20;
  localparam int PW     = 20;
  localparam int OW     = 12;
  localparam int CLK_NS = 10;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          lookup_valid_i = 0, refill_valid_i = 0, refill_dirty_i = 0;
  logic          inv_all_i = 0, inv_page_i = 0;
  logic [VW-1:0] lookup_vpn_i = '0, refill_vpn_i = '0, inv_vpn_i = '0;
  logic [OW-1:0] lookup_off_i = '0;
  logic [1:0]    lookup_acc_i = '0;
  logic [PW-1:0] refill_ppn_i = '0;
  logic [2:0]    refill_perm_i = '0;
  logic          resp_valid_o, resp_hit_o, resp_miss_o;
  logic [PW-1:0] resp_ppn_o;
  logic [2:0]    resp_perm_o;
  logic [PW+OW-1:0] resp_pa_o;

  tlb_fa #(.ENTRIES(N), .VPN_W(VW), .PPN_W(PW), .OFF_W(OW)) uut (.*);

  always #(CLK_NS / 2) clk_i = ~clk_i;

  int    n_cmp = 0, n_bad = 0;
  string cur_req = "R1";
  bit    finished = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit         m_valid[N], m_used[N], m_dirty[N];
  int         m_vpn[N], m_ppn[N];
  bit [2:0]   m_perm[N];
  bit         e_valid, e_hit, e_miss;
  bit [PW-1:0] e_ppn;
  bit [2:0]   e_perm;
  bit [OW-1:0] e_off;
  int         lj, rj;
  bit         all_used;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) begin m_valid[i] = 0; m_used[i] = 0; end
      e_valid = 0; e_hit = 0; e_miss = 0;
    end else begin
      lj = -1;
      for (int i = 0; i < N; i++) if (m_valid[i] && m_vpn[i] == int'(lookup_vpn_i)) lj = i;
      e_valid = lookup_valid_i;
      e_hit   = lookup_valid_i && lj >= 0 && !(lookup_acc_i == 2'd1 && !m_dirty[lj]);
      e_miss  = lookup_valid_i && !e_hit;
      e_ppn   = e_hit ? PW'(m_ppn[lj]) : '0;
      e_perm  = e_hit ? m_perm[lj] : 3'b0;
      e_off   = lookup_off_i;
      rj = -1; all_used = 0;
      for (int i = 0; i < N; i++) if (m_valid[i] && m_vpn[i] == int'(refill_vpn_i)) rj = i;
      if (rj < 0) for (int i = N - 1; i >= 0; i--) if (!m_valid[i]) rj = i;
      if (rj < 0) for (int i = N - 1; i >= 0; i--) if (!m_used[i]) rj = i;
      if (rj < 0) begin all_used = 1; rj = 0; end
      if (e_hit) m_used[lj] = 1;
      if (inv_all_i) begin
        for (int i = 0; i < N; i++) begin m_valid[i] = 0; m_used[i] = 0; end
      end else if (inv_page_i) begin
        for (int i = 0; i < N; i++)
          if (m_valid[i] && m_vpn[i] == int'(inv_vpn_i)) begin m_valid[i] = 0; m_used[i] = 0; end
      end else if (refill_valid_i) begin
        if (all_used) for (int i = 0; i < N; i++) m_used[i] = 0;
        m_valid[rj] = 1; m_used[rj] = 1; m_dirty[rj] = refill_dirty_i;
        m_vpn[rj] = int'(refill_vpn_i); m_ppn[rj] = int'(refill_ppn_i); m_perm[rj] = refill_perm_i;
      end
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni && !finished) begin
      chk(cur_req, {61'd0, resp_valid_o, resp_hit_o, resp_miss_o}, {61'd0, e_valid, e_hit, e_miss});
      if (e_valid)
        chk(cur_req, {resp_ppn_o, resp_perm_o, resp_pa_o}, {e_ppn, e_perm, e_ppn, e_off});
    end
  end

  function automatic logic [PW-1:0] map(input logic [VW-1:0] v);
    return v ^ 20'h5a000;
  endfunction

  task automatic lookup(input logic [VW-1:0] v, input logic [1:0] a, input logic [OW-1:0] o);
    lookup_valid_i = 1; lookup_vpn_i = v; lookup_acc_i = a; lookup_off_i = o;
    @(negedge clk_i);
    lookup_valid_i = 0;
  endtask

  task automatic refill(input logic [VW-1:0] v, input logic [PW-1:0] p, input logic d);
    refill_valid_i = 1; refill_vpn_i = v; refill_ppn_i = p; refill_perm_i = 3'b110; refill_dirty_i = d;
    @(negedge clk_i);
    refill_valid_i = 0;
  endtask

  task automatic expect_lk(input string req, input logic [VW-1:0] v, input logic [1:0] a,
                           input bit hit, input logic [PW-1:0] p);
    lookup(v, a, 12'h3a5);
    chk(req, {63'd0, resp_hit_o}, {63'd0, hit});
    if (hit) begin
      chk(req, {32'd0, resp_pa_o}, {32'd0, p, 12'h3a5});
      chk(req, {61'd0, resp_perm_o}, 64'd6);
    end else chk(req, {44'd0, resp_ppn_o}, 64'd0);
  endtask

  int loop_hits;

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    cur_req = "R1";
    chk("R1", {63'd0, resp_valid_o}, 64'd0);
    expect_lk("R1", 20'd5, 2'd0, 0, '0);
    @(negedge clk_i);
    chk("R2", {61'd0, resp_valid_o, resp_hit_o, resp_miss_o}, 64'd0);

    cur_req = "R6";
    for (int v = 100; v < 100 + N; v++) refill(VW'(v), map(VW'(v)), v[0]);
    cur_req = "R3";
    for (int v = 100; v < 100 + N; v++) expect_lk("R3", VW'(v), 2'd0, 1, map(VW'(v)));

    cur_req = "R5";
    expect_lk("R5", 20'd100, 2'd1, 0, '0);
    expect_lk("R5", 20'd101, 2'd1, 1, map(20'd101));
    expect_lk("R5", 20'd100, 2'd2, 1, map(20'd100));

    cur_req = "R7";
    refill(20'd103, 20'h77777, 1'b1);
    expect_lk("R7", 20'd103, 2'd0, 1, 20'h77777);
    expect_lk("R7", 20'd102, 2'd0, 1, map(20'd102));

    cur_req = "R9";
    refill(20'd200, map(20'd200), 1'b1);
    expect_lk("R9", 20'd100, 2'd0, 0, '0);
    expect_lk("R9", 20'd200, 2'd0, 1, map(20'd200));
    expect_lk("R9", 20'd115, 2'd0, 1, map(20'd115));

    cur_req = "R8";
    refill(20'd201, map(20'd201), 1'b1);
    expect_lk("R8", 20'd101, 2'd0, 0, '0);
    expect_lk("R8", 20'd201, 2'd0, 1, map(20'd201));
    expect_lk("R8", 20'd102, 2'd0, 1, map(20'd102));
    refill(20'd202, map(20'd202), 1'b1);
    expect_lk("R8", 20'd103, 2'd0, 0, '0);
    expect_lk("R8", 20'd202, 2'd0, 1, map(20'd202));
    expect_lk("R8", 20'd102, 2'd0, 1, map(20'd102));

    cur_req = "R11";
    inv_page_i = 1; inv_vpn_i = 20'd104; @(negedge clk_i); inv_page_i = 0;
    expect_lk("R11", 20'd104, 2'd0, 0, '0);
    expect_lk("R11", 20'd105, 2'd0, 1, map(20'd105));

    cur_req = "R12";
    inv_page_i = 1; inv_vpn_i = 20'd105;
    refill_valid_i = 1; refill_vpn_i = 20'd300; refill_ppn_i = map(20'd300); refill_dirty_i = 1;
    @(negedge clk_i);
    inv_page_i = 0; refill_valid_i = 0;
    expect_lk("R12", 20'd300, 2'd0, 0, '0);
    expect_lk("R12", 20'd105, 2'd0, 0, '0);

    cur_req = "R10";
    inv_all_i = 1; @(negedge clk_i); inv_all_i = 0;
    expect_lk("R10", 20'd200, 2'd0, 0, '0);
    expect_lk("R10", 20'd106, 2'd0, 0, '0);

    cur_req = "R13";
    loop_hits = 0;
    for (int pass = 0; pass < 4; pass++)
      for (int v = 400; v < 400 + N; v++) begin
        lookup(VW'(v), 2'd0, OW'(v));
        if (resp_hit_o) loop_hits++;
        else refill(VW'(v), map(VW'(v)), 1'b1);
      end
    chk("R13", 64'(loop_hits), 64'(3 * N));

    cur_req = "R8";
    for (int pass = 0; pass < 3; pass++)
      for (int v = 500; v < 501 + N; v++) begin
        lookup(VW'(v), 2'(v % 3), OW'(v));
        if (!resp_hit_o) refill(VW'(v), map(VW'(v)), v[1]);
      end

    repeat (2) @(negedge clk_i);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      finished = 1;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule